// File: doc/BRIEF.md
# Maskable Interrupt Controller with Wake

This block gathers 32 level-sensitive interrupt sources into a raw pending vector. Sources 0 to 10 are individual GPIO requests, source 11 is the merged request of the upper GPIO group, and the remaining sources come from on-chip peripherals, one of which is a real-time-clock alarm. A per-source enable register gates the raw vector. A per-source steering register sends each enabled pending source to either the normal interrupt line or the fast interrupt line. Both lines are registered and active high.

Software reaches the block through a simple register port with a single-cycle write strobe and a registered read path. Beyond the enable and steering registers, the port exposes the steered pending vectors and the raw vector. It also holds a one-bit idle-exit qualifier and a wake-enable register. The wake-enable register raises a wake request from selected GPIO edge pulses or from the alarm source. A helper output gives the lowest-numbered pending normal interrupt, so a dispatcher can skip a software bit scan.

Top module: `pic_wake_ctrl`

## Requirements
- R1: After a synchronous reset, the enable, steering, qualifier and wake-enable registers all read zero, and `irq_o`, `fiq_o`, `wake_o` and `irq_idx_vld_o` are low.
- R2: A source whose enable bit is 0 never contributes to `irq_o`, `fiq_o` or the steered pending vectors.
- R3: An enabled pending source with steering bit 0 drives `irq_o`. With steering bit 1 it drives `fiq_o` instead.
- R4: The outputs `irq_o`, `fiq_o`, `irq_idx_o`, `irq_idx_vld_o`, `wake_o` and `idle_exit_o` reflect the inputs and registers one clock edge after they are applied. A source is cleared by dropping its input, and no acknowledge is needed.
- R5: Read address 4 returns raw AND enable AND NOT steering. Address 5 returns raw AND enable AND steering. Address 6 returns the raw vector. `rd_data_o` is valid one edge after `rd_addr_i` is applied.
- R6: `irq_idx_o` gives the lowest bit number that is set in the normal pending vector. `irq_idx_vld_o` is 1 exactly when that vector is nonzero.
- R7: `wake_o` is 1 when, for some i in 0..27, `gpio_edge_i[i]` and wake-enable bit i are both 1. It is also 1 when source 31 (the alarm) is high and wake-enable bit 31 is 1. Wake-enable bits 28 to 30 cannot be written and read zero.
- R8: With qualifier bit 0 (address 2) at 1, `idle_exit_o` rises only for enabled pending sources. With it at 0, any raw pending source raises `idle_exit_o`.
- R9: The writable registers sit at addresses 0 (enable), 1 (steering), 2 (qualifier, bit 0 only) and 3 (wake-enable), and each reads back what was written. Writes to addresses 4 to 7 change nothing, and address 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Raw level interrupt sources |
| gpio_edge_i | input | 28 | GPIO edge-detect pulses used for wake |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| irq_idx_o | output | 5 | Lowest pending normal source |
| irq_idx_vld_o | output | 1 | `irq_idx_o` is meaningful |
| wake_o | output | 1 | Wake request |
| idle_exit_o | output | 1 | Idle-state exit request |

## Verification
Each output has exactly one register between its inputs and its pin. A register write therefore becomes visible on the outputs two edges after the strobe is driven: one edge to update the register, one to register the output. A source change becomes visible one edge after it is applied. The bench drives inputs at a falling edge and waits two rising edges before sampling on the next falling edge, which covers both latencies. Reads present an address at a falling edge and sample `rd_data_o` after the following rising edge, while sources stay steady throughout the read.

// File: rtl/pic_wake_pkg.sv
package pic_wake_pkg;
  localparam int PIC_DW = 32;
  localparam int PIC_AW = 3;
  localparam logic [PIC_AW-1:0] ADR_ENA  = 3'd0;
  localparam logic [PIC_AW-1:0] ADR_STEER = 3'd1;
  localparam logic [PIC_AW-1:0] ADR_QUAL = 3'd2;
  localparam logic [PIC_AW-1:0] ADR_WAKE = 3'd3;
  localparam logic [PIC_AW-1:0] ADR_PIRQ = 3'd4;
  localparam logic [PIC_AW-1:0] ADR_PFIQ = 3'd5;
  localparam logic [PIC_AW-1:0] ADR_RAW  = 3'd6;

  typedef struct packed {
    logic [PIC_DW-1:0] ena;
    logic [PIC_DW-1:0] steer;
    logic [PIC_DW-1:0] wake;
    logic              qual;
  } pic_cfg_t;
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_wake_pkg::*;
#(
  parameter int N_GPIO_WAKE = 28,
  parameter int WAKE_RTC_BIT = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [PIC_AW-1:0] wr_addr_i,
  input  logic [PIC_DW-1:0] wr_data_i,
  input  logic [PIC_AW-1:0] rd_addr_i,
  input  logic [PIC_DW-1:0] pend_irq_i,
  input  logic [PIC_DW-1:0] pend_fiq_i,
  input  logic [PIC_DW-1:0] raw_i,
  output pic_cfg_t          cfg_o,
  output logic [PIC_DW-1:0] rd_data_o
);
  localparam logic [PIC_DW-1:0] WAKE_WMASK =
    ((PIC_DW'(1) << N_GPIO_WAKE) - PIC_DW'(1)) | (PIC_DW'(1) << WAKE_RTC_BIT);

  pic_cfg_t cfg_q;
  logic [PIC_DW-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADR_ENA:   cfg_q.ena   <= wr_data_i;
        ADR_STEER: cfg_q.steer <= wr_data_i;
        ADR_QUAL:  cfg_q.qual  <= wr_data_i[0];
        ADR_WAKE:  cfg_q.wake  <= wr_data_i & WAKE_WMASK;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (rd_addr_i)
      ADR_ENA:   rd_mux = cfg_q.ena;
      ADR_STEER: rd_mux = cfg_q.steer;
      ADR_QUAL:  rd_mux = {{(PIC_DW-1){1'b0}}, cfg_q.qual};
      ADR_WAKE:  rd_mux = cfg_q.wake;
      ADR_PIRQ:  rd_mux = pend_irq_i;
      ADR_PFIQ:  rd_mux = pend_fiq_i;
      ADR_RAW:   rd_mux = raw_i;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= rd_mux;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/pic_route.sv
module pic_route #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] raw_i,
  input  logic [N_SRC-1:0] ena_i,
  input  logic [N_SRC-1:0] steer_i,
  input  logic             qual_i,
  output logic [N_SRC-1:0] pend_irq_o,
  output logic [N_SRC-1:0] pend_fiq_o,
  output logic             irq_o,
  output logic             fiq_o,
  output logic             idle_exit_o
);
  logic [N_SRC-1:0] gated;
  logic             idle_d;

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_lane
      assign gated[g]      = raw_i[g] & ena_i[g];
      assign pend_irq_o[g] = gated[g] & ~steer_i[g];
      assign pend_fiq_o[g] = gated[g] &  steer_i[g];
    end
  endgenerate

  assign idle_d = qual_i ? (|gated) : (|raw_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o       <= 1'b0;
      fiq_o       <= 1'b0;
      idle_exit_o <= 1'b0;
    end else begin
      irq_o       <= |pend_irq_o;
      fiq_o       <= |pend_fiq_o;
      idle_exit_o <= idle_d;
    end
  end
endmodule

// File: rtl/pic_low_idx.sv
module pic_low_idx #(
  parameter int N_SRC = 32,
  localparam int IDXW = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] vec_i,
  output logic [IDXW-1:0]  idx_o,
  output logic             vld_o
);
  logic [IDXW-1:0] idx_d;

  always_comb begin
    idx_d = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_d = IDXW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_o <= '0;
      vld_o <= 1'b0;
    end else begin
      idx_o <= idx_d;
      vld_o <= |vec_i;
    end
  end
endmodule

// File: rtl/pic_wake_gen.sv
module pic_wake_gen #(
  parameter int N_GPIO_WAKE = 28
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_GPIO_WAKE-1:0] edge_i,
  input  logic [N_GPIO_WAKE-1:0] gpio_en_i,
  input  logic                   rtc_i,
  input  logic                   rtc_en_i,
  output logic                   wake_o
);
  always_ff @(posedge clk) begin
    if (rst) wake_o <= 1'b0;
    else     wake_o <= (|(edge_i & gpio_en_i)) | (rtc_i & rtc_en_i);
  end
endmodule

// File: rtl/pic_wake_ctrl.sv
module pic_wake_ctrl
  import pic_wake_pkg::*;
#(
  parameter int N_GPIO_WAKE = 28,
  parameter int RTC_IDX = 31,
  parameter int WAKE_RTC_BIT = 31,
  localparam int N_SRC = PIC_DW,
  localparam int IDXW = $clog2(N_SRC)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_SRC-1:0]       src_i,
  input  logic [N_GPIO_WAKE-1:0] gpio_edge_i,
  input  logic                   wr_en_i,
  input  logic [PIC_AW-1:0]      wr_addr_i,
  input  logic [PIC_DW-1:0]      wr_data_i,
  input  logic [PIC_AW-1:0]      rd_addr_i,
  output logic [PIC_DW-1:0]      rd_data_o,
  output logic                   irq_o,
  output logic                   fiq_o,
  output logic [IDXW-1:0]        irq_idx_o,
  output logic                   irq_idx_vld_o,
  output logic                   wake_o,
  output logic                   idle_exit_o
);
  pic_cfg_t         cfg;
  logic [N_SRC-1:0] pend_irq;
  logic [N_SRC-1:0] pend_fiq;

  pic_cfg_regs #(.N_GPIO_WAKE(N_GPIO_WAKE), .WAKE_RTC_BIT(WAKE_RTC_BIT)) regs_i (
    .clk(clk), .rst(rst),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i),
    .pend_irq_i(pend_irq), .pend_fiq_i(pend_fiq), .raw_i(src_i),
    .cfg_o(cfg), .rd_data_o(rd_data_o)
  );

  pic_route #(.N_SRC(N_SRC)) route_i (
    .clk(clk), .rst(rst),
    .raw_i(src_i), .ena_i(cfg.ena), .steer_i(cfg.steer), .qual_i(cfg.qual),
    .pend_irq_o(pend_irq), .pend_fiq_o(pend_fiq),
    .irq_o(irq_o), .fiq_o(fiq_o), .idle_exit_o(idle_exit_o)
  );

  pic_low_idx #(.N_SRC(N_SRC)) idx_i (
    .clk(clk), .rst(rst), .vec_i(pend_irq),
    .idx_o(irq_idx_o), .vld_o(irq_idx_vld_o)
  );

  pic_wake_gen #(.N_GPIO_WAKE(N_GPIO_WAKE)) wake_i (
    .clk(clk), .rst(rst),
    .edge_i(gpio_edge_i), .gpio_en_i(cfg.wake[N_GPIO_WAKE-1:0]),
    .rtc_i(src_i[RTC_IDX]), .rtc_en_i(cfg.wake[WAKE_RTC_BIT]),
    .wake_o(wake_o)
  );
endmodule

// File: rtl/pic_wake_ctrl_chk.sv
module pic_wake_ctrl_chk #(
  parameter int N_SRC = 32,
  parameter int IDXW = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-1:0] src_i,
  input logic [N_SRC-1:0] ena,
  input logic [N_SRC-1:0] wake_en,
  input logic [N_SRC-1:0] pend_irq,
  input logic             irq_o,
  input logic             fiq_o,
  input logic [IDXW-1:0]  irq_idx_o,
  input logic             irq_idx_vld_o,
  input logic             wake_o,
  input logic             idle_exit_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && !fiq_o && !wake_o && !irq_idx_vld_o));

  assert_masked_silent_R2: assert property (@(posedge clk) disable iff (rst)
    (irq_o || fiq_o) |-> ($past(src_i & ena) != '0));

  assert_idx_has_irq_R6: assert property (@(posedge clk) disable iff (rst)
    irq_idx_vld_o |-> irq_o);

  assert_idx_lowest_R6: assert property (@(posedge clk) disable iff (rst)
    irq_idx_vld_o |-> ((($past(pend_irq) >> irq_idx_o) & 1) == 1 &&
                      ($past(pend_irq) & ((N_SRC'(1) << irq_idx_o) - N_SRC'(1))) == '0));

  assert_wake_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> ($past(wake_en) != '0));

  assert_idle_needs_source_R8: assert property (@(posedge clk) disable iff (rst)
    idle_exit_o |-> ($past(src_i) != '0));
endmodule

bind pic_wake_ctrl pic_wake_ctrl_chk #(.N_SRC(N_SRC), .IDXW(IDXW)) chk_i (
  .clk(clk), .rst(rst), .src_i(src_i), .ena(cfg.ena), .wake_en(cfg.wake),
  .pend_irq(pend_irq), .irq_o(irq_o), .fiq_o(fiq_o), .irq_idx_o(irq_idx_o),
  .irq_idx_vld_o(irq_idx_vld_o), .wake_o(wake_o), .idle_exit_o(idle_exit_o)
);

// File: tb/pic_wake_ctrl_tb.sv
`timescale 1ns/100ps
module pic_wake_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src = '0;
  logic [27:0] gedge = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq, fiq, vld, wake, idle;
  logic [4:0]  idx;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] m_ena = '0, m_steer = '0, m_wake = '0;
  logic        m_qual = 1'b0;
  localparam logic [31:0] WMASK = 32'h8FFF_FFFF;

  always #2.5 clk = ~clk;

  pic_wake_ctrl dut_i (
    .clk(clk), .rst(rst), .src_i(src), .gpio_edge_i(gedge),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_o(irq), .fiq_o(fiq), .irq_idx_o(idx), .irq_idx_vld_o(vld),
    .wake_o(wake), .idle_exit_o(idle)
  );

  function automatic logic [31:0] e_pirq();
    return src & m_ena & ~m_steer;
  endfunction
  function automatic logic [31:0] e_pfiq();
    return src & m_ena & m_steer;
  endfunction
  function automatic logic [4:0] e_idx();
    logic [31:0] v = e_pirq();
    for (int i = 0; i < 32; i++) if (v[i]) return 5'(i);
    return 5'd0;
  endfunction
  function automatic logic e_wake();
    return (|(gedge & m_wake[27:0])) | (src[31] & m_wake[31]);
  endfunction
  function automatic logic e_idle();
    return m_qual ? (|(src & m_ena)) : (|src);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    case (a)
      3'd0: m_ena = d;
      3'd1: m_steer = d;
      3'd2: m_qual = d[0];
      3'd3: m_wake = d & WMASK;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    @(posedge clk); @(negedge clk);
    d = rd_data;
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic check_outs(input string tag);
    logic [31:0] pi = e_pirq();
    chk({"R3 irq ", tag}, 32'(irq), 32'(|pi));
    chk({"R3 fiq ", tag}, 32'(fiq), 32'(|e_pfiq()));
    chk({"R6 vld ", tag}, 32'(vld), 32'(|pi));
    if (|pi) chk({"R6 idx ", tag}, 32'(idx), 32'(e_idx()));
    chk({"R7 wake ", tag}, 32'(wake), 32'(e_wake()));
    chk({"R8 idle ", tag}, 32'(idle), 32'(e_idle()));
  endtask

  task automatic check_pend(input string tag);
    logic [31:0] d;
    rd(3'd4, d); chk({"R5 pirq ", tag}, d, e_pirq());
    rd(3'd5, d); chk({"R5 pfiq ", tag}, d, e_pfiq());
    rd(3'd6, d); chk({"R5 raw ", tag}, d, src);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", 32'(irq), 0); chk("R1 fiq", 32'(fiq), 0);
    chk("R1 wake", 32'(wake), 0); chk("R1 vld", 32'(vld), 0);
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), d); chk("R1 reg zero", d, 0);
    end
    // R2 all masked, sources active
    src = 32'hFFFF_FFFF; settle();
    chk("R2 irq masked", 32'(irq), 0); chk("R2 fiq masked", 32'(fiq), 0);
    rd(3'd4, d); chk("R2 pirq masked", d, 0);
    chk("R8 idle any raw", 32'(idle), 1);
    // R8 qualified idle
    wr(3'd2, 32'h1); settle();
    chk("R8 idle qualified masked", 32'(idle), 0);
    // R9 readback and ignored writes
    wr(3'd0, 32'hA5A5_0F0F); rd(3'd0, d); chk("R9 ena rb", d, 32'hA5A5_0F0F);
    wr(3'd1, 32'h0000_FFFF); rd(3'd1, d); chk("R9 steer rb", d, 32'h0000_FFFF);
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, d); chk("R7 wake bits 28-30 zero", d, 32'h8FFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF); rd(3'd7, d); chk("R9 addr7 zero", d, 0);
    wr(3'd4, 32'h0); wr(3'd6, 32'h0);
    rd(3'd0, d); chk("R9 ro write ignored ena", d, 32'hA5A5_0F0F);
    rd(3'd1, d); chk("R9 ro write ignored steer", d, 32'h0000_FFFF);
    rd(3'd3, d); chk("R9 ro write ignored wake", d, 32'h8FFF_FFFF);
    // R6 boundaries, R4 one-edge latency
    wr(3'd3, 0); wr(3'd1, 0); wr(3'd0, 32'hFFFF_FFFF);
    src = 32'h8000_0000; settle(); check_outs("bit31");
    chk("R6 idx 31", 32'(idx), 31);
    src = 32'h8000_0001; @(posedge clk); @(negedge clk);
    chk("R4 idx next edge", 32'(idx), 0);
    src = 32'h0; @(posedge clk); @(negedge clk);
    chk("R4 irq clears no ack", 32'(irq), 0);
    chk("R6 vld clears", 32'(vld), 0);
    // R3 steering all to fast
    wr(3'd1, 32'hFFFF_FFFF); src = 32'h0000_0800; settle();
    chk("R3 steer to fiq", 32'(fiq), 1); chk("R3 not irq", 32'(irq), 0);
    // R7 alarm wake and gpio wake
    wr(3'd3, 32'h8000_0000); src = 32'h8000_0000; settle();
    chk("R7 alarm wake", 32'(wake), 1);
    src = 0; gedge = 28'h800_0000; wr(3'd3, 32'h0800_0000); settle();
    chk("R7 gpio27 wake", 32'(wake), 1);
    gedge = 28'h400_0000; settle();
    chk("R7 unselected edge", 32'(wake), 0);
    // random phase
    for (int it = 0; it < 400; it++) begin
      src = (it % 3 == 0) ? ($urandom() & $urandom()) : $urandom();
      gedge = 28'($urandom() & $urandom() & $urandom());
      wr(3'd0, $urandom());
      wr(3'd1, $urandom());
      wr(3'd2, $urandom());
      wr(3'd3, $urandom() & $urandom());
      settle();
      check_outs("rand");
      check_pend("rand");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule